// File: doc/BRIEF.md
# GF(2^32) Additive-FFT Butterfly

This block applies the butterfly step of an additive FFT over the binary field GF(2^32) to a stream of element pairs. Every pair (u, w) in a batch shares one twiddle element, called lambda here. The block first forms the new u as u plus lambda times w. It then forms the new w as w plus that new u, not the old one. Addition in the field is XOR. Multiplication is a 32x32 carryless product, folded back into 32 bits modulo x^32 + x^15 + x^9 + x^7 + x^4 + x^3 + 1.

Pairs travel in beats of `LANES` pairs, with a valid/ready handshake at the input and at the output. Each beat carries a lane mask, so a batch whose length is not a multiple of `LANES` is finished by a partial beat. Lambda is written through a separate configuration strobe before a batch starts. The block honours that write only when nothing is inside the pipeline; otherwise it refuses the write and raises a one-cycle error flag. Stage scheduling, twiddle generation and addressing are left to the surrounding engine.

Top module: `gfbf_butterfly`

## Requirements
- R1: After reset, `out_valid` and `cfg_reject` are 0, lambda is 0 and `in_ready` is 1.
- R2: For every active lane, the output u equals u XOR r. Here r is the carryless product lambda*w reduced modulo the 33-bit polynomial 0x1_0000_8299.
- R3: For every active lane, the output w equals w XOR (the output u of the same lane).
- R4: With lambda equal to 0, an active lane yields u unchanged and w XOR u.
- R5: Lane g occupies bits [32g+31:32g] of `in_u`, `in_w`, `out_u` and `out_w`, and bit g of the lane masks. The output mask equals the input mask of the beat. A lane whose mask bit is 0 produces 0 on both outputs, so a partial beat is still correct in its active lanes.
- R6: Beats leave in the order they entered, one output beat per accepted input beat. With `out_ready` held high, a beat accepted at clock edge k appears on the outputs after edge k+1. Whenever `out_ready` is 1, `in_ready` is 1.
- R7: While `out_valid` is 1 and `out_ready` is 0, the output beat (valid, mask, u and w) stays unchanged on the next cycle.
- R8: A lambda write (`cfg_lambda_valid` high at an edge) is accepted only when no beat is in the pipeline and no input transfer happens at that same edge. Beats accepted afterwards use the new value, and `cfg_reject` stays 0.
- R9: A write refused under R8 leaves lambda unchanged and sets `cfg_reject` to 1 for exactly the next cycle. `cfg_reject` is 0 after any cycle without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lambda_valid | input | 1 | Strobe requesting a lambda write |
| cfg_lambda | input | 32 | Lambda value to write |
| cfg_reject | output | 1 | Pulses for one cycle after a refused write |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_lanes | input | LANES | Active-lane mask of the input beat |
| in_u | input | LANES*32 | u elements, lane 0 in the low bits |
| in_w | input | LANES*32 | w elements, lane 0 in the low bits |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the output beat |
| out_lanes | output | LANES | Active-lane mask of the output beat |
| out_u | output | LANES*32 | Updated u elements |
| out_w | output | LANES*32 | Updated w elements, formed from the updated u |

## Verification
The hardest cases to reach from the ports are the lambda write racing the stream. One is a write that arrives while a beat sits in the first stage. Another is a write in the same cycle as an input transfer into an empty pipeline. The stimulus drains the pipeline, then issues the write exactly one cycle after a beat is pushed, and also alongside a lone beat. It then checks that the later results still carry the old lambda. The multiplier and the fold are covered by sweeping lambda and w over all single-bit basis pairs under random output back-pressure, followed by random and all-ones operands that drive the product's highest bits through both fold steps.

// File: rtl/gfbf_pkg.sv
package gfbf_pkg;
   // field width and the low part of the field polynomial (x^32 term implied)
   localparam int unsigned FW       = 32;
   localparam logic [FW-1:0] POLY_LOW = 32'h0000_8299;

   typedef logic [FW-1:0]     elem_t;
   typedef logic [2*FW-2:0]   prod_t;
endpackage

// File: rtl/gfbf_clmul.sv
module gfbf_clmul #(
   parameter int unsigned W = 32,
   localparam int unsigned PW = 2*W-1
) (
   input  logic [W-1:0]  a,
   input  logic [W-1:0]  b,
   output logic [PW-1:0] p
);
   if (W < 2) begin : g_bad_w
      $error("gfbf_clmul: W must be at least 2");
   end

   // shift-and-xor partial products, one per set bit of b
   always_comb begin
      p = '0;
      for (int i = 0; i < W; i++) begin
         if (b[i]) p ^= ({{(W-1){1'b0}}, a} << i);
      end
   end
endmodule

// File: rtl/gfbf_fold.sv
module gfbf_fold
   import gfbf_pkg::*;
(
   input  prod_t prod,
   output elem_t red
);
   // the two-step fold is exact only while the polynomial tail has degree < FW/2
   if ((POLY_LOW >> (FW/2)) != 0) begin : g_bad_poly
      $error("gfbf_fold: polynomial tail too high for a two-step fold");
   end

   elem_t hi, lo, tmp;

   assign hi = {1'b0, prod[2*FW-2:FW]};
   assign lo = prod[FW-1:0];

   always_comb begin
      // first step: bits of hi*tail that spill past FW
      tmp = hi;
      for (int k = 1; k < FW; k++) begin
         if (POLY_LOW[k]) tmp ^= hi >> (FW - k);
      end
      // second step: tmp*tail lands fully inside FW bits
      red = lo;
      for (int k = 0; k < FW; k++) begin
         if (POLY_LOW[k]) red ^= tmp << k;
      end
   end
endmodule

// File: rtl/gfbf_lane.sv
module gfbf_lane
   import gfbf_pkg::*;
#(
   parameter bit MUL_REG = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ld,
   input  elem_t lam,
   input  elem_t w_new,
   input  elem_t u_st,
   input  elem_t w_st,
   input  logic  act,
   output elem_t u_nx,
   output elem_t w_nx
);
   elem_t mul_b;
   prod_t mul_p;
   prod_t fold_in;
   elem_t red;

   if (MUL_REG) begin : g_pre
      // multiply at the input edge, register the raw product
      prod_t prod_q;
      assign mul_b = w_new;
      always_ff @(posedge clk) begin
         if (!rst_n)  prod_q <= '0;
         else if (ld) prod_q <= mul_p;
      end
      assign fold_in = prod_q;
   end else begin : g_post
      // multiply and fold in the second stage from the staged w
      assign mul_b   = w_st;
      assign fold_in = mul_p;
   end

   gfbf_clmul #(.W(FW)) mul_i (
      .a (lam),
      .b (mul_b),
      .p (mul_p)
   );

   gfbf_fold fold_i (
      .prod (fold_in),
      .red  (red)
   );

   elem_t u_upd;
   assign u_upd = u_st ^ red;
   assign u_nx  = act ? u_upd          : '0;
   assign w_nx  = act ? (w_st ^ u_upd) : '0;
endmodule

// File: rtl/gfbf_butterfly.sv
module gfbf_butterfly
   import gfbf_pkg::*;
#(
   parameter int unsigned LANES   = 2,
   parameter bit          MUL_REG = 1'b1,
   localparam int unsigned VW     = LANES*FW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_lambda_valid,
   input  logic [FW-1:0]    cfg_lambda,
   output logic             cfg_reject,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [LANES-1:0] in_lanes,
   input  logic [VW-1:0]    in_u,
   input  logic [VW-1:0]    in_w,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [LANES-1:0] out_lanes,
   output logic [VW-1:0]    out_u,
   output logic [VW-1:0]    out_w
);
   if (LANES < 1 || LANES > 16) begin : g_bad_lanes
      $error("gfbf_butterfly: LANES must lie in 1..16");
   end

   // stage A: staged operands
   logic             a_vld;
   logic [LANES-1:0] a_lanes;
   logic [VW-1:0]    a_u, a_w;
   logic [VW-1:0]    nxt_u, nxt_w;
   elem_t            lam_q;

   logic b_adv, a_adv, in_fire, pipe_busy, lam_ok;

   assign b_adv     = !out_valid || out_ready;
   assign a_adv     = !a_vld || b_adv;
   assign in_ready  = a_adv;
   assign in_fire   = in_valid && a_adv;
   assign pipe_busy = a_vld || out_valid;
   assign lam_ok    = cfg_lambda_valid && !pipe_busy && !in_fire;

   // twiddle register with in-flight guard
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lam_q      <= '0;
         cfg_reject <= 1'b0;
      end else begin
         if (lam_ok) lam_q <= cfg_lambda;
         cfg_reject <= cfg_lambda_valid && !lam_ok;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_vld   <= 1'b0;
         a_lanes <= '0;
         a_u     <= '0;
         a_w     <= '0;
      end else if (a_adv) begin
         a_vld <= in_valid;
         if (in_valid) begin
            a_lanes <= in_lanes;
            a_u     <= in_u;
            a_w     <= in_w;
         end
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      gfbf_lane #(.MUL_REG(MUL_REG)) lane_i (
         .clk   (clk),
         .rst_n (rst_n),
         .ld    (in_fire),
         .lam   (lam_q),
         .w_new (in_w[g*FW +: FW]),
         .u_st  (a_u[g*FW +: FW]),
         .w_st  (a_w[g*FW +: FW]),
         .act   (a_lanes[g]),
         .u_nx  (nxt_u[g*FW +: FW]),
         .w_nx  (nxt_w[g*FW +: FW])
      );
   end

   // stage B: output register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_lanes <= '0;
         out_u     <= '0;
         out_w     <= '0;
      end else if (b_adv) begin
         out_valid <= a_vld;
         if (a_vld) begin
            out_lanes <= a_lanes;
            out_u     <= nxt_u;
            out_w     <= nxt_w;
         end
      end
   end
endmodule

// File: rtl/gfbf_butterfly_chk.sv
module gfbf_butterfly_chk #(
   parameter int unsigned LANES = 2,
   parameter int unsigned FW    = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_lambda_valid,
   input logic             cfg_reject,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [LANES-1:0] out_lanes,
   input logic [LANES*FW-1:0] out_u,
   input logic [LANES*FW-1:0] out_w
);
   logic [1:0] occ;
   logic       in_f, out_f, idle_ok;

   assign in_f  = in_valid && in_ready;
   assign out_f = out_valid && out_ready;

   // occupancy seen purely from the handshakes
   always_ff @(posedge clk) begin
      if (!rst_n) occ <= '0;
      else        occ <= occ + {1'b0, in_f} - {1'b0, out_f};
   end

   always_comb begin
      idle_ok = 1'b1;
      for (int g = 0; g < LANES; g++) begin
         if (!out_lanes[g] && (out_u[g*FW +: FW] != '0 || out_w[g*FW +: FW] != '0))
            idle_ok = 1'b0;
      end
   end

   p_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_ready |-> in_ready);

   p_depth_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (occ <= 2'd2) && (!out_valid || occ != 2'd0));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_lanes)
                                  && $stable(out_u) && $stable(out_w));

   p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_lambda_valid && occ == 2'd0 && !in_f |=> !cfg_reject);

   p_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_lambda_valid && (occ != 2'd0 || in_f) |=> cfg_reject);

   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_lambda_valid |=> !cfg_reject);

   p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> idle_ok);
endmodule

bind gfbf_butterfly gfbf_butterfly_chk #(.LANES(LANES), .FW(gfbf_pkg::FW)) chk_i (
   .clk              (clk),
   .rst_n            (rst_n),
   .cfg_lambda_valid (cfg_lambda_valid),
   .cfg_reject       (cfg_reject),
   .in_valid         (in_valid),
   .in_ready         (in_ready),
   .out_valid        (out_valid),
   .out_ready        (out_ready),
   .out_lanes        (out_lanes),
   .out_u            (out_u),
   .out_w            (out_w)
);

// File: tb/gfbf_butterfly_tb_top.sv
`timescale 1ns/1ps
module gfbf_butterfly_tb_top;
   localparam int unsigned LANES = 2;
   localparam int unsigned FW    = 32;
   localparam int unsigned VW    = LANES*FW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_lambda_valid = 1'b0;
   logic [FW-1:0] cfg_lambda = '0;
   logic cfg_reject;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [LANES-1:0] in_lanes = '0;
   logic [VW-1:0] in_u = '0, in_w = '0;
   logic out_valid;
   logic out_ready = 1'b1;
   logic [LANES-1:0] out_lanes;
   logic [VW-1:0] out_u, out_w;

   always #10 clk = ~clk;

   gfbf_butterfly #(.LANES(LANES)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_lambda_valid(cfg_lambda_valid), .cfg_lambda(cfg_lambda), .cfg_reject(cfg_reject),
      .in_valid(in_valid), .in_ready(in_ready), .in_lanes(in_lanes), .in_u(in_u), .in_w(in_w),
      .out_valid(out_valid), .out_ready(out_ready), .out_lanes(out_lanes),
      .out_u(out_u), .out_w(out_w)
   );

   int n_chk = 0, n_fail = 0, cyc = 0, occ = 0;
   logic [31:0] rs = 32'h1234_5679;
   logic [31:0] lam_model = '0;
   bit bp_en = 0, cfg_req = 0, pend_cfg = 0, pend_rej = 0, prev_stall = 0;
   logic [31:0] cfg_val = '0;
   logic [LANES-1:0] held_m;
   logic [VW-1:0] held_u, held_w;
   string ctx = "";

   logic [LANES-1:0] src_m[$], exp_m[$];
   logic [VW-1:0] src_u[$], src_w[$], exp_u[$], exp_w[$];
   logic [31:0] exp_l[$];
   int exp_t[$];
   bit exp_nb[$];

   function automatic logic [31:0] rnd();
      rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
      return rs;
   endfunction

   // plain multiply then bit-by-bit polynomial reduction
   function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
      logic [63:0] p = '0;
      for (int i = 0; i < 32; i++) if (b[i]) p ^= {32'b0, a} << i;
      for (int i = 62; i >= 32; i--) if (p[i]) p ^= {31'b0, 33'h1_0000_8299} << (i - 32);
      return p[31:0];
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s %s actual=%h expected=%h", req, ctx, what, act, exp);
      end
   endtask

   task automatic push(input logic [LANES-1:0] m, input logic [VW-1:0] u, input logic [VW-1:0] w);
      src_m.push_back(m); src_u.push_back(u); src_w.push_back(w);
   endtask

   task automatic cycle();
      bit in_f, out_f, acc;
      logic [VW-1:0] eu, ew;
      logic [31:0] uu;
      @(negedge clk);
      cyc++;
      if (src_u.size() > 0) begin
         in_valid = 1'b1; in_lanes = src_m[0]; in_u = src_u[0]; in_w = src_w[0];
      end else begin
         in_valid = 1'b0;
      end
      out_ready = bp_en ? (rnd() % 3 != 0) : 1'b1;
      cfg_lambda_valid = cfg_req; cfg_lambda = cfg_val; cfg_req = 0;
      #8;
      // R8 / R9: outcome of the previous cycle's write
      if (pend_cfg) chk(cfg_reject == pend_rej, pend_rej ? "R9" : "R8", "cfg_reject",
                        64'(cfg_reject), 64'(pend_rej));
      else if (cfg_reject) chk(1'b0, "R9", "spurious cfg_reject", 64'(cfg_reject), 64'd0);
      if (prev_stall)
         chk(out_valid && out_lanes == held_m && out_u == held_u && out_w == held_w,
             "R7", "held beat u", out_u, held_u);
      in_f  = in_valid && in_ready;
      out_f = out_valid && out_ready;
      if (in_f) begin
         for (int g = 0; g < LANES; g++) begin
            uu = in_u[g*FW +: FW] ^ ref_mul(lam_model, in_w[g*FW +: FW]);
            eu[g*FW +: FW] = in_lanes[g] ? uu : '0;
            ew[g*FW +: FW] = in_lanes[g] ? (in_w[g*FW +: FW] ^ uu) : '0;
         end
         exp_m.push_back(in_lanes); exp_u.push_back(eu); exp_w.push_back(ew);
         exp_l.push_back(lam_model); exp_t.push_back(cyc); exp_nb.push_back(!bp_en);
         void'(src_m.pop_front()); void'(src_u.pop_front()); void'(src_w.pop_front());
      end
      if (out_f) begin
         if (exp_u.size() == 0) chk(1'b0, "R6", "unexpected beat", out_u, 64'd0);
         else begin
            chk(out_lanes == exp_m[0], "R5", "lane mask", 64'(out_lanes), 64'(exp_m[0]));
            for (int g = 0; g < LANES; g++) begin
               chk(out_u[g*FW +: FW] == exp_u[0][g*FW +: FW], exp_l[0] == 0 ? "R4" : "R2",
                   $sformatf("u lane %0d", g), 64'(out_u[g*FW +: FW]), 64'(exp_u[0][g*FW +: FW]));
               chk(out_w[g*FW +: FW] == exp_w[0][g*FW +: FW], exp_l[0] == 0 ? "R4" : "R3",
                   $sformatf("w lane %0d", g), 64'(out_w[g*FW +: FW]), 64'(exp_w[0][g*FW +: FW]));
            end
            if (exp_nb[0] && !bp_en)
               chk(cyc - exp_t[0] == 2, "R6", "latency", 64'(cyc - exp_t[0]), 64'd2);
            void'(exp_m.pop_front()); void'(exp_u.pop_front()); void'(exp_w.pop_front());
            void'(exp_l.pop_front()); void'(exp_t.pop_front()); void'(exp_nb.pop_front());
         end
      end
      if (out_ready) chk(in_ready, "R6", "in_ready with out_ready", 64'(in_ready), 64'd1);
      acc = cfg_lambda_valid && occ == 0 && !in_f;
      pend_cfg = cfg_lambda_valid;
      pend_rej = cfg_lambda_valid && !acc;
      if (acc) lam_model = cfg_lambda;
      prev_stall = out_valid && !out_ready;
      held_m = out_lanes; held_u = out_u; held_w = out_w;
      occ = occ + int'(in_f) - int'(out_f);
   endtask

   task automatic drain();
      for (int i = 0; i < 400 && (src_u.size() > 0 || exp_u.size() > 0); i++) cycle();
      cycle();
   endtask

   task automatic load_lambda(input logic [31:0] v);
      drain();
      cfg_req = 1; cfg_val = v;
      cycle();
      cycle();
   endtask

   function automatic logic [LANES-1:0] rmask();
      logic [31:0] r = rnd();
      return r[LANES-1:0];
   endfunction

   initial begin
      #3_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
      chk(cfg_reject == 1'b0, "R1", "cfg_reject in reset", 64'(cfg_reject), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);

      // R1 lambda resets to 0, so this batch exercises R4 without a write
      ctx = "R1/R4";
      for (int i = 0; i < 6; i++) push('1, {rnd(), rnd()}, {rnd(), rnd()});
      drain();
      ctx = "R4";
      load_lambda(32'h0);
      for (int i = 0; i < 6; i++) push('1, {rnd(), rnd()}, {rnd(), rnd()});
      drain();

      // basis sweep under back-pressure (R2, R3, R7)
      ctx = "sweep";
      bp_en = 1;
      for (int li = 0; li < 32; li++) begin
         load_lambda(32'h1 << li);
         for (int wi = 0; wi < 32; wi += 2)
            push('1, {rnd(), rnd()}, {32'h1 << (wi + 1), 32'h1 << wi});
      end
      drain();

      // random lambdas with partial and empty masks (R5)
      ctx = "R5 random";
      for (int k = 0; k < 16; k++) begin
         load_lambda(rnd());
         for (int i = 0; i < 8; i++) push(rmask(), {rnd(), rnd()}, {rnd(), rnd()});
      end
      drain();

      // high-degree corners through both fold steps
      bp_en = 0;
      ctx = "corners";
      load_lambda(32'hFFFF_FFFF);
      push('1, {32'h0, 32'h1}, {32'hFFFF_FFFF, 32'h8000_0000});
      push(2'b10, {32'h5A5A_5A5A, 32'h0}, {32'h8000_0001, 32'hFFFF_FFFF});
      load_lambda(32'h8000_0000);
      push('1, {32'hFFFF_FFFF, 32'h0}, {32'h8000_0000, 32'hC000_0000});
      drain();

      // R9: write while a beat is in flight is refused, old lambda kept
      ctx = "R9";
      load_lambda(32'h0000_0003);
      for (int i = 0; i < 3; i++) push('1, {rnd(), rnd()}, {rnd(), rnd()});
      cycle();
      cfg_req = 1; cfg_val = 32'hDEAD_BEEF;
      cycle();
      cycle();
      chk(lam_model == 32'h3, "R9", "lambda after refused write", 64'(lam_model), 64'h3);
      drain();
      for (int i = 0; i < 2; i++) push('1, {rnd(), rnd()}, {rnd(), rnd()});
      drain();

      // R8: write in the same cycle as a transfer into an empty pipe is refused
      ctx = "R8 same-cycle";
      push(2'b01, {rnd(), rnd()}, {rnd(), rnd()});
      cfg_req = 1; cfg_val = 32'h1234_0000;
      cycle();
      cycle();
      chk(lam_model == 32'h3, "R8", "lambda after colliding write", 64'(lam_model), 64'h3);
      drain();
      ctx = "R8 accepted";
      load_lambda(32'h0F0F_1234);
      chk(lam_model == 32'h0F0F_1234, "R8", "lambda after clean write", 64'(lam_model), 64'h0F0F_1234);
      for (int i = 0; i < 4; i++) push(rmask(), {rnd(), rnd()}, {rnd(), rnd()});
      drain();

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule